// File: doc/BRIEF.md
# Flag-Controlled Combinational ALU

This block is a purely combinational 16-bit arithmetic/logic unit that has no opcode field. Six independent control flags define the operation. Two flags per operand either zero the operand or pass it through, and then either invert it or leave it alone. A select flag chooses between a bitwise AND and a modular sum of the two conditioned operands. A last flag can complement the chosen result. Every operation the unit offers is one setting of these six flags. Some examples are sum, pass-through, NOR, subtraction forms and all-ones or all-zero constants.

Three status outputs classify the result for conditional branching: zero, negative (top bit set) and strictly positive. The result is always visible on its own port. A separate drive enable gates a bus-facing copy of the result, which reads as all zeros while the enable is low. The operand registers sit outside the block, and the block has no carry or overflow output.

Top module: `flag_alu`

## Requirements
- R1: When `keep_x` is 0, the X operand is replaced by zero before any inversion, so `keep_x`=0 with `flip_x`=1 yields an all-ones X operand.
- R2: When `flip_x` is 1, every bit of the (possibly zeroed) X operand is complemented before the function stage.
- R3: `keep_y` and `flip_y` act on Y exactly as `keep_x` and `flip_x` act on X: zeroing first, complement second.
- R4: With `sum_sel` 0, the function stage outputs the bitwise AND of the two conditioned operands.
- R5: With `sum_sel` 1, the function stage outputs the sum of the two conditioned operands modulo 2^16, and the carry is dropped (0xFFFF + 0x0001 gives 0x0000).
- R6: When `flip_out` is 1, `result` is the bitwise complement of the function stage output.
- R7: `is_zero` is 1 exactly when `result` equals 0x0000.
- R8: `is_neg` equals bit 15 of `result`.
- R9: `is_pos` is 1 exactly when `result` is neither zero nor negative. At all times exactly one of `is_zero`, `is_neg` and `is_pos` is 1.
- R10: `bus_data` equals `result` while `drive_en` is 1 and is 0x0000 while `drive_en` is 0. `drive_en` has no effect on `result` or on the status outputs.
- R11: The flag set {keep_x, keep_y, sum_sel} gives X+Y. The set {keep_x, sum_sel} gives X unchanged. The set {keep_x, flip_x, keep_y, flip_y} gives NOR of X and Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_in | input | 16 | X operand |
| y_in | input | 16 | Y operand |
| keep_x | input | 1 | 1 passes X, 0 forces it to zero |
| flip_x | input | 1 | complement conditioned X |
| keep_y | input | 1 | 1 passes Y, 0 forces it to zero |
| flip_y | input | 1 | complement conditioned Y |
| sum_sel | input | 1 | 0 selects AND, 1 selects addition |
| flip_out | input | 1 | complement the function output |
| drive_en | input | 1 | gate result onto bus_data |
| result | output | 16 | ALU result |
| bus_data | output | 16 | gated copy of result |
| is_zero | output | 1 | result is zero |
| is_neg | output | 1 | result bit 15 set |
| is_pos | output | 1 | result nonzero and not negative |

## Verification
Every output is combinational, so all results are due in the same cycle as the stimulus and no register sits between the inputs and any port. The bench applies each new operand and flag set just after a rising edge. It samples `result`, the three status bits and `bus_data` at the following falling edge, after the logic has settled and well before the next change of the inputs. A behavioural model, written with plain integers, predicts the values for that same cycle.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
    localparam int unsigned DATA_W = 16;

    typedef struct packed {
        logic keep_x;
        logic flip_x;
        logic keep_y;
        logic flip_y;
        logic sum_sel;
        logic flip_out;
    } alu_ctl_t;

    typedef struct packed {
        logic zero;
        logic neg;
        logic pos;
    } alu_stat_t;
endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] raw,
    input  logic         keep,
    input  logic         flip,
    output logic [W-1:0] cond
);
    typedef struct packed {
        logic [W-1:0] gated;
        logic [W-1:0] shaped;
    } cond_t;

    cond_t stage_d;

    always_comb begin
        stage_d.gated  = keep ? raw : '0;
        stage_d.shaped = flip ? ~stage_d.gated : stage_d.gated;
    end

    assign cond = stage_d.shaped;

    always_comb begin
        if (!keep) begin
            AST_ZERO_BEFORE_FLIP: assert (cond == (flip ? {W{1'b1}} : {W{1'b0}}))
                else $error("operand zeroing order broken"); // R1, R3
        end
        if (keep) begin
            AST_FLIP_BITWISE: assert ((cond ^ raw) == (flip ? {W{1'b1}} : {W{1'b0}}))
                else $error("operand inversion broken"); // R2, R3
        end
    end
endmodule

// File: rtl/alu_func_core.sv
module alu_func_core #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         sum_sel,
    input  logic         flip_out,
    output logic [W-1:0] res
);
    typedef struct packed {
        logic [W-1:0] conj;
        logic [W-1:0] sum;
        logic [W-1:0] picked;
        logic [W-1:0] final_v;
    } core_t;

    core_t core_d;

    always_comb begin
        core_d.conj    = opa & opb;
        core_d.sum     = opa + opb;
        core_d.picked  = sum_sel ? core_d.sum : core_d.conj;
        core_d.final_v = flip_out ? ~core_d.picked : core_d.picked;
    end

    assign res = core_d.final_v;

    always_comb begin
        if (!sum_sel && !flip_out) begin
            AST_AND_SUBSET: assert ((res & ~opa) == '0 && (res & ~opb) == '0)
                else $error("AND result has stray bits"); // R4
        end
        if (sum_sel && !flip_out && opb == '0) begin
            AST_ADD_IDENTITY: assert (res == opa)
                else $error("adding zero changed operand"); // R5
        end
        if (flip_out && !sum_sel) begin
            AST_FLIP_OUT_NAND: assert ((~res & ~opa) == '0 || (~res & ~opb) == '0 || (~res) == (opa & opb))
                else $error("output inversion broken"); // R6
        end
    end
endmodule

// File: rtl/alu_status.sv
module alu_status
    import flag_alu_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] val,
    output alu_stat_t    stat
);
    localparam int unsigned SIGN_BIT = W - 1;

    alu_stat_t stat_d;

    always_comb begin
        stat_d.zero = (val == '0);
        stat_d.neg  = val[SIGN_BIT];
        stat_d.pos  = !stat_d.zero && !stat_d.neg;
    end

    assign stat = stat_d;

    always_comb begin
        AST_ONE_CLASS: assert ($countones({stat.zero, stat.neg, stat.pos}) == 1)
            else $error("status classes not exclusive"); // R9
        if (stat.pos) begin
            AST_POS_NONZERO: assert (val != '0 && !val[SIGN_BIT])
                else $error("positive flag on non-positive value"); // R9
        end
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
(
    input  logic [15:0] x_in,
    input  logic [15:0] y_in,
    input  logic        keep_x,
    input  logic        flip_x,
    input  logic        keep_y,
    input  logic        flip_y,
    input  logic        sum_sel,
    input  logic        flip_out,
    input  logic        drive_en,
    output logic [15:0] result,
    output logic [15:0] bus_data,
    output logic        is_zero,
    output logic        is_neg,
    output logic        is_pos
);
    localparam int unsigned W = DATA_W;
    localparam int unsigned N_OPS = 2;

    alu_ctl_t        ctl;
    logic [W-1:0]    raw_ops  [N_OPS];
    logic [W-1:0]    cond_ops [N_OPS];
    logic [N_OPS-1:0] keep_v;
    logic [N_OPS-1:0] flip_v;
    logic [W-1:0]    func_res;
    alu_stat_t       stat;

    assign ctl = '{keep_x: keep_x, flip_x: flip_x, keep_y: keep_y,
                   flip_y: flip_y, sum_sel: sum_sel, flip_out: flip_out};

    assign raw_ops[0] = x_in;
    assign raw_ops[1] = y_in;
    assign keep_v     = {ctl.keep_y, ctl.keep_x};
    assign flip_v     = {ctl.flip_y, ctl.flip_x};

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_opnd
        alu_operand_cond #(.W(W)) u_cond (
            .raw  (raw_ops[gi]),
            .keep (keep_v[gi]),
            .flip (flip_v[gi]),
            .cond (cond_ops[gi])
        );
    end

    alu_func_core #(.W(W)) u_core (
        .opa      (cond_ops[0]),
        .opb      (cond_ops[1]),
        .sum_sel  (ctl.sum_sel),
        .flip_out (ctl.flip_out),
        .res      (func_res)
    );

    alu_status #(.W(W)) u_stat (
        .val  (func_res),
        .stat (stat)
    );

    assign result   = func_res;
    assign bus_data = drive_en ? func_res : '0;
    assign is_zero  = stat.zero;
    assign is_neg   = stat.neg;
    assign is_pos   = stat.pos;

    always_comb begin
        if (!drive_en) begin
            AST_BUS_RELEASED: assert (bus_data == '0)
                else $error("bus driven while disabled"); // R10
        end else begin
            AST_BUS_MIRRORS: assert (bus_data == result)
                else $error("bus differs from result"); // R10
        end
        AST_ZERO_MATCH: assert (is_zero == (result == 16'h0000))
            else $error("zero flag mismatch"); // R7
        AST_SIGN_MATCH: assert (is_neg == result[15])
            else $error("sign flag mismatch"); // R8
    end
endmodule

// File: tb/flag_alu_test.sv
`timescale 1ns/1ps
module flag_alu_test;
    logic        clk = 1'b0;
    logic [15:0] x_in = '0, y_in = '0;
    logic        keep_x = 0, flip_x = 0, keep_y = 0, flip_y = 0;
    logic        sum_sel = 0, flip_out = 0, drive_en = 0;
    logic [15:0] result, bus_data;
    logic        is_zero, is_neg, is_pos;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    flag_alu uut (
        .x_in(x_in), .y_in(y_in), .keep_x(keep_x), .flip_x(flip_x),
        .keep_y(keep_y), .flip_y(flip_y), .sum_sel(sum_sel),
        .flip_out(flip_out), .drive_en(drive_en), .result(result),
        .bus_data(bus_data), .is_zero(is_zero), .is_neg(is_neg), .is_pos(is_pos)
    );

    function automatic int model(int x, int y, bit kx, bit fx, bit ky, bit fy, bit s, bit fo);
        int a, b, r;
        a = kx ? x : 0;
        if (fx) a = 65535 - a;
        b = ky ? y : 0;
        if (fy) b = 65535 - b;
        r = s ? (a + b) % 65536 : (a & b);
        if (fo) r = 65535 - r;
        return r;
    endfunction

    task automatic check(string tag, string what, int got, int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic apply(string tag, int x, int y, bit kx, bit fx, bit ky,
                         bit fy, bit s, bit fo, bit de, int want);
        int exp_r;
        @(posedge clk);
        #0.5;
        x_in = x[15:0]; y_in = y[15:0];
        keep_x = kx; flip_x = fx; keep_y = ky; flip_y = fy;
        sum_sel = s; flip_out = fo; drive_en = de;
        exp_r = model(x, y, kx, fx, ky, fy, s, fo);
        @(negedge clk);
        if (want >= 0) check(tag, "hand value", exp_r, want);
        check(tag, "result", int'(result), exp_r);
        check("R7", "is_zero", int'(is_zero), (exp_r == 0) ? 1 : 0);
        check("R8", "is_neg", int'(is_neg), (exp_r >= 32768) ? 1 : 0);
        check("R9", "is_pos", int'(is_pos), (exp_r > 0 && exp_r < 32768) ? 1 : 0);
        check("R10", "bus_data", int'(bus_data), de ? exp_r : 0);
    endtask

    initial begin
        #50000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int lfsr;
        @(negedge clk);
        check("R1", "idle result", int'(result), 0);
        check("R7", "idle zero", int'(is_zero), 1);
        check("R10", "idle bus", int'(bus_data), 0);
        // R1 R3 R4: both operands zeroed then inverted, AND gives all ones
        apply("R1", 16'h1234, 16'h5678, 0, 1, 0, 1, 0, 0, 1, 16'hFFFF);
        // R3: zeroed Y kills the AND
        apply("R3", 16'hFFFF, 16'hFFFF, 1, 0, 0, 0, 0, 0, 1, 0);
        // R11: X+Y
        apply("R11", 16'h1234, 16'h1111, 1, 0, 1, 0, 1, 0, 1, 16'h2345);
        // R11: pass X
        apply("R11", 16'h00AB, 16'hFFFF, 1, 0, 0, 0, 1, 0, 1, 16'h00AB);
        // R11: NOR
        apply("R11", 16'hF0F0, 16'h0F00, 1, 1, 1, 1, 0, 0, 1, 16'h000F);
        // R5: carry dropped
        apply("R5", 16'hFFFF, 16'h0001, 1, 0, 1, 0, 1, 0, 1, 0);
        // R4: AND, positive
        apply("R4", 16'hFF00, 16'h0FF0, 1, 0, 1, 0, 0, 0, 1, 16'h0F00);
        // R6: inverted AND
        apply("R6", 16'hFF00, 16'h0FF0, 1, 0, 1, 0, 0, 1, 1, 16'hF0FF);
        // R2: ~x + y = y - x - 1
        apply("R2", 5, 10, 1, 1, 1, 0, 1, 0, 1, 4);
        // R3: ~(x + ~y) = y - x
        apply("R3", 3, 10, 1, 0, 1, 1, 1, 1, 1, 7);
        // R8: sign bit alone
        apply("R8", 16'h8000, 0, 1, 0, 0, 0, 1, 0, 1, 16'h8000);
        // R10: drive disabled, result still present
        apply("R10", 16'h0042, 0, 1, 0, 0, 0, 1, 0, 0, 16'h0042);
        lfsr = 32'h1ACE;
        for (int i = 0; i < 400; i++) begin
            int xv, yv, fl;
            lfsr = ((lfsr << 1) ^ (((lfsr >> 30) ^ (lfsr >> 27)) & 1)) & 32'h7FFFFFFF;
            xv = lfsr & 16'hFFFF;
            fl = (lfsr >> 16) & 8'h7F;
            lfsr = ((lfsr * 1103515245) + 12345) & 32'h7FFFFFFF;
            yv = (lfsr >> 7) & 16'hFFFF;
            if (i % 16 == 0) yv = 0;
            apply("R11", xv, yv, fl[0], fl[1], fl[2], fl[3], fl[4], fl[5], fl[6], -1);
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule